// File: doc/BRIEF.md
# Round-Robin Serial ADC Sampler

This block is a cut-down serial-peripheral master that runs on its own. Once out of reset it reads a set of external serial ADCs one after another, with no help from a host. All converters share a single serial data input. The block produces the serial clock and a chip-select strobe. It also drives a channel code that selects which converter is active.

A two-bit mode input sets the sample width and the way the channel code is used:
- In the quad mode a single four-channel converter is served. The low two code bits drive that converter's channel-select lines directly.
- In the other modes up to eight single-channel converters are served. The three-bit code feeds an external active-low 3-to-8 decoder, gated by the strobe.

Each channel keeps its most recent result in a register. A host reads that register through a simple read port. A per-channel fresh flag tells the host whether a new result has arrived since its last read.

Top module: `rr_adc_sampler`

## Requirements
- R1: While reset is held, the chip-select strobe is high, the serial clock is low, the done pulse is low, and every result register and fresh flag is zero.
- R2: The mode code sets the sample width and the channel range. Code 0 gives 12 bits on channels 0 to 3 only, with code bit 2 kept at 0. Code 1 gives 15 bits on channels 0 to 7. Codes 2 and 3 give 16 bits on channels 0 to 7.
- R3: A frame has exactly as many serial-clock rising edges as the sample width. The data input is sampled at each rising edge, most significant bit first, and the result is stored right-aligned and zero-extended.
- R4: The serial clock is low whenever the strobe is high. During a frame, each high phase of the serial clock lasts div_i+1 system clocks.
- R5: The first serial-clock rising edge of a frame comes at least 2*(div_i+1) system clocks after the strobe falls.
- R6: Between two frames the strobe stays high for at least 4*(div_i+1) system clocks.
- R7: Channels are served in ascending order, wrapping from 7 to 0. Channels that are not enabled are skipped. The first frame after reset goes to the lowest enabled channel.
- R8: A disabled channel never gets a frame. When no channel is enabled the strobe stays high, and a disabled channel's register keeps its value.
- R9: A result register changes only at the end of a frame on its own channel. At that moment done_o pulses for one cycle, done_ch_o gives the channel, and the strobe rises.
- R10: A channel's fresh flag is set when its register is updated and cleared when it is read. A read returns the data and the flag one cycle after rd_en_i. If an update lands in the same cycle as a read, the flag stays set.
- R11: The channel code does not change while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Converter mode (R2), captured at frame start |
| div_i | input | DIV_W | Serial-clock half period minus one, in system clocks |
| ch_en_i | input | 8 | Channel enable mask |
| miso_i | input | 1 | Shared serial data input |
| sclk_o | output | 1 | Serial clock |
| cs_en_n_o | output | 1 | Active-low frame strobe / decoder enable |
| cs_code_o | output | 3 | Channel code (select lines or decoder input) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 3 | Channel to read |
| rd_data_o | output | 16 | Read result |
| rd_fresh_o | output | 1 | Fresh flag of the channel read |
| done_o | output | 1 | One-cycle pulse at the end of each frame |
| done_ch_o | output | 3 | Channel of the frame just finished |

## Verification
The bench sweeps every mode, two divider settings and masks that are full, sparse, a single channel, or empty for the active range. It targets the following faults:
- A width or bit-order fault would leave the all-ones and LSB-only patterns shifted or truncated.
- A selection fault would either skip a channel or visit a disabled one. In quad mode it would also reach channels 4 to 7.
- A timing fault would shorten the strobe gap, the set-up time or the serial-clock high phase below the divided period.
- A fault in the fresh-flag logic would show as a flag that stays set after a read, or as data that changes on a channel with no new frame.

// File: rtl/rr_adc_sampler.sv
module rr_adc_sampler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       ch_en_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             cs_en_n_o,
  output logic [2:0]       cs_code_o,
  input  logic             rd_en_i,
  input  logic [2:0]       rd_addr_i,
  output logic [15:0]      rd_data_o,
  output logic             rd_fresh_o,
  output logic             done_o,
  output logic [2:0]       done_ch_o
);
  localparam int NCH  = 8;
  localparam int CH_W = $clog2(NCH);
  localparam int DW   = 16;
  localparam int BC_W = $clog2(DW + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_GAP} st_t;

  function automatic logic [BC_W-1:0] wbits(input logic [1:0] m);
    case (m)
      2'd0:    return BC_W'(12);
      2'd1:    return BC_W'(15);
      default: return BC_W'(16);
    endcase
  endfunction

  st_t              st;
  logic [DIV_W-1:0] dcnt;
  logic [2:0]       ph;
  logic [BC_W-1:0]  bitcnt;
  logic [CH_W-1:0]  cur, nxt;
  logic [1:0]       wmode;
  logic [DW-1:0]    shreg;
  logic             sclk_q, cs_q, done_q;
  logic [DW-1:0]    res [NCH];
  logic [NCH-1:0]   fresh;
  logic [NCH-1:0]   emask;
  logic             tick, fin;

  assign tick  = (dcnt >= div_i);
  assign emask = (mode_i == 2'd0) ? (ch_en_i & 8'h0F) : ch_en_i;
  assign fin   = tick && st == S_SHIFT && !sclk_q && bitcnt == wbits(wmode);

  always_comb begin
    logic found;
    found = 1'b0;
    nxt   = cur;
    for (int i = 1; i <= NCH; i++) begin
      if (!found && emask[cur + CH_W'(i)]) begin
        nxt   = cur + CH_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dcnt <= '0;
    else        dcnt <= tick ? '0 : dcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= '0;
      bitcnt <= '0;
      cur    <= CH_W'(NCH - 1);
      wmode  <= '0;
      shreg  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (|emask) begin
            cur    <= nxt;
            wmode  <= mode_i;
            cs_q   <= 1'b0;
            ph     <= '0;
            bitcnt <= '0;
            shreg  <= '0;
            st     <= S_SETUP;
          end
          S_SETUP: begin
            ph <= ph + 1'b1;
            if (ph == 3'd1) st <= S_SHIFT;
          end
          S_SHIFT: begin
            if (sclk_q) sclk_q <= 1'b0;
            else if (fin) begin
              cs_q   <= 1'b1;
              done_q <= 1'b1;
              ph     <= '0;
              st     <= S_GAP;
            end else begin
              sclk_q <= 1'b1;
              shreg  <= {shreg[DW-2:0], miso_i};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          default: begin
            ph <= ph + 1'b1;
            if (ph == 3'd3) st <= S_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh      <= '0;
      rd_data_o  <= '0;
      rd_fresh_o <= 1'b0;
      for (int i = 0; i < NCH; i++) res[i] <= '0;
    end else begin
      if (rd_en_i) begin
        rd_data_o  <= res[rd_addr_i];
        rd_fresh_o <= fresh[rd_addr_i];
        fresh[rd_addr_i] <= 1'b0;
      end
      if (fin) begin
        res[cur]   <= shreg;
        fresh[cur] <= 1'b1;
      end
    end
  end

  assign sclk_o    = sclk_q;
  assign cs_en_n_o = cs_q;
  assign cs_code_o = cur;
  assign done_o    = done_q;
  assign done_ch_o = cur;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_en_n_o |-> !sclk_o);  // R4
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_en_n_o && $past(!cs_en_n_o)) |-> $stable(cs_code_o));  // R11
  AST_QUAD_LOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_en_n_o && wmode == 2'd0) |-> !cs_code_o[2]);  // R2
  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= wbits(wmode));  // R3
  AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(cs_en_n_o));  // R9
  AST_FRESH_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> fresh[done_ch_o]);  // R10
endmodule

// File: tb/test_rr_adc_sampler.sv
module test_rr_adc_sampler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [7:0]  div_i = '0;
  logic [7:0]  ch_en_i = '0;
  logic        miso_i = 1'b0;
  logic        sclk_o, cs_en_n_o, rd_fresh_o, done_o;
  logic [2:0]  cs_code_o, done_ch_o;
  logic        rd_en_i = 1'b0;
  logic [2:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;

  always #5 clk = ~clk;

  rr_adc_sampler #(.DIV_W(8)) i_rr_adc_sampler (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .div_i(div_i), .ch_en_i(ch_en_i),
    .miso_i(miso_i), .sclk_o(sclk_o), .cs_en_n_o(cs_en_n_o), .cs_code_o(cs_code_o),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .rd_fresh_o(rd_fresh_o), .done_o(done_o), .done_ch_o(done_ch_o));

  int n_tests = 0, n_fail = 0;
  int W = 12, DV = 0, frames = 0, exp_prev = 7;
  logic [7:0]  emask = '0;
  logic [15:0] val [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt_en(input int p, input logic [7:0] m);
    for (int i = 1; i <= 8; i++) if (m[(p + i) % 8]) return (p + i) % 8;
    return -1;
  endfunction

  // converter model: only the selected channel drives the shared line
  int k = 0;
  logic [15:0] cur_val = '0;
  always @(negedge cs_en_n_o) begin
    #1;
    k = 0;
    cur_val = val[cs_code_o];
    miso_i = cur_val[W-1];
  end
  always @(posedge sclk_o) k++;
  always @(negedge sclk_o) if (!cs_en_n_o) miso_i = (k < W) ? cur_val[W-1-k] : 1'b0;

  // bus monitor
  logic prev_cs = 1'b1, prev_sclk = 1'b0, seen_gap = 1'b0;
  int hi_cnt = 0, setup_cnt = 0, sh_cnt = 0, rises = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b0; seen_gap = 1'b0;
      hi_cnt = 0; setup_cnt = 0; sh_cnt = 0; rises = 0; frames = 0; exp_prev = 7;
    end else begin
      if (prev_cs && !cs_en_n_o) begin
        if (seen_gap) chk(hi_cnt >= 4*(DV+1), "R6 gap", hi_cnt, 4*(DV+1));
        chk(emask[cs_code_o] == 1'b1, "R8 disabled channel selected", int'(cs_code_o), nxt_en(exp_prev, emask));
        chk(int'(cs_code_o) == nxt_en(exp_prev, emask), "R7 order", int'(cs_code_o), nxt_en(exp_prev, emask));
        if (mode_i == 2'd0) chk(cs_code_o < 3'd4, "R2 quad range", int'(cs_code_o), 3);
        exp_prev = cs_code_o; setup_cnt = 0; rises = 0;
      end
      if (!prev_cs && cs_en_n_o) begin
        chk(rises == W, "R3 edges per frame", rises, W);
        seen_gap = 1'b1; hi_cnt = 0;
      end
      if (cs_en_n_o) hi_cnt++;
      if (!cs_en_n_o && rises == 0 && !sclk_o) setup_cnt++;
      if (!prev_sclk && sclk_o) begin
        if (rises == 0) chk(setup_cnt >= 2*(DV+1), "R5 setup", setup_cnt, 2*(DV+1));
        rises++; sh_cnt = 1;
      end else if (sclk_o) sh_cnt++;
      if (prev_sclk && !sclk_o) chk(sh_cnt == DV+1, "R4 high phase", sh_cnt, DV+1);
      if (done_o) begin
        chk(int'(done_ch_o) == exp_prev, "R9 done channel", int'(done_ch_o), exp_prev);
        frames++;
      end
      prev_cs = cs_en_n_o; prev_sclk = sclk_o;
    end
  end

  task automatic rd(input int c, output logic [15:0] d, output logic f);
    @(negedge clk); rd_en_i = 1'b1; rd_addr_i = 3'(c);
    @(negedge clk); rd_en_i = 1'b0; d = rd_data_o; f = rd_fresh_o;
  endtask

  task automatic run_cfg(input int m, input int d, input logic [7:0] msk, input int seed);
    logic [15:0] dd;
    logic ff;
    int target, snap, t;
    rst_n = 1'b0;
    mode_i = 2'(m); div_i = 8'(d); ch_en_i = msk;
    DV = d;
    W = (m == 0) ? 12 : (m == 1) ? 15 : 16;
    emask = (m == 0) ? (msk & 8'h0F) : msk;
    for (int c = 0; c < 8; c++) val[c] = 16'((c*4973 + seed*313 + 17) % (1 << W));
    val[1] = 16'((1 << W) - 1);
    val[2] = 16'd1;
    repeat (3) @(negedge clk);
    chk(cs_en_n_o && !sclk_o && !done_o, "R1 bus idle in reset", {cs_en_n_o, sclk_o, done_o}, 4);
    chk(rd_data_o == 16'd0 && !rd_fresh_o, "R1 read port in reset", int'(rd_data_o), 0);
    rst_n = 1'b1;
    target = 2*$countones(emask) + 1;
    if ($countones(emask) == 0) target = 0;
    t = 0;
    while (frames < target && t < 20000) begin @(negedge clk); t++; end
    if (target == 0) repeat (400) @(negedge clk);
    ch_en_i = 8'h00;
    repeat (80*(d+1)) @(negedge clk);
    snap = frames;
    repeat (100*(d+1)) @(negedge clk);
    chk(frames == snap && frames >= target, "R8 no frames when disabled", frames, snap);
    chk(cs_en_n_o == 1'b1, "R8 strobe idle", int'(cs_en_n_o), 1);
    for (int c = 0; c < 8; c++) begin
      rd(c, dd, ff);
      if (emask[c]) begin
        chk(dd == val[c], "R3 sample value", int'(dd), int'(val[c]));
        chk(ff == 1'b1, "R10 fresh after update", int'(ff), 1);
        rd(c, dd, ff);
        chk(ff == 1'b0, "R10 fresh cleared by read", int'(ff), 0);
        chk(dd == val[c], "R9 result held", int'(dd), int'(val[c]));
      end else begin
        chk(dd == 16'd0 && ff == 1'b0, "R8 disabled register untouched", int'(dd), 0);
      end
    end
  endtask

  initial begin
    int seed = 0;
    for (int m = 0; m < 4; m++)
      for (int di = 0; di < 2; di++) begin
        run_cfg(m, di*2, 8'hFF, seed++);
        run_cfg(m, di*2, 8'h5A, seed++);
        run_cfg(m, di*2, 8'h10, seed++);
      end
    run_cfg(1, 0, 8'h00, seed++);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1900000;
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule